// File: doc/BRIEF.md
# Host Interrupt Mask and Status Unit

This unit gathers up to sixteen single-cycle event pulses from the device into a sticky status register and drives one host interrupt line from them. Each status bit stays set from the pulse that set it until the host removes it. The host can remove bits one at a time by writing ones to an acknowledge register, or remove all of them by reading the clear-on-read status view. A second status view returns the same bits and leaves them unchanged.

A mask bit set to 1 keeps the matching status bit from raising the host line. The host can write the whole mask at once. It can also change single mask bits, without touching the others, through a write-only set alias and a write-only clear alias. A configuration register turns the host line on and selects its polarity. A small state machine (states ST_OFF, ST_QUIET, ST_RAISED) tracks the line. From any state it goes to ST_OFF when the enable is off. It goes to ST_RAISED when the enable is on and an unmasked status bit is pending, and to ST_QUIET when the enable is on and nothing unmasked is pending. These states are computed from the next register values, so the line changes on the same clock edge as the status, mask or configuration that causes the change.

Source bit usage in the system: 0 receive buffer 0 data, 1 transmit data, 2 transmit transfer, 3 receive buffer 1 data, 4 receive transfer, 5 and 6 event mailbox, 7 wake, 8 and 9 debug trace, 10 command complete, 14 initialization complete. The remaining bits are spare.

Top module: `hirq_ctrl`

## Requirements
- R1: The mask register is at address 0 and is read/write. It resets to 0x0001. A 1 in a mask bit masks that interrupt from the host.
- R2: A write to address 1 (mask set alias) sets the mask bits that are 1 in the written data and leaves all other mask bits as they were.
- R3: A write to address 2 (mask clear alias) clears the mask bits that are 1 in the written data and leaves all other mask bits as they were. Reads of addresses 1, 2 and 5 return 0.
- R4: A read of address 3 returns the status bits and does not change them.
- R5: A read of address 4 returns the status bits and clears all of them on the clock edge that ends the read.
- R6: A write to address 5 clears each status bit that is 1 in the written data, as seen at both status addresses. Status bits written as 0 are kept.
- R7: A 1 on source bit i sets status bit i at the next clock edge. The bit stays set until it is acknowledged or cleared by a read. A source pulse in the same cycle as an acknowledge or a clear-on-read of that bit wins, so the bit stays set.
- R8: The configuration register is at address 6. Bit 5 is the host enable and bit 7 selects an active-low line. Reads of address 6 return only these two bits, and the register resets to 0.
- R9: With the enable on, host_irq is at its active level exactly when some status bit is set whose mask bit is 0. The active level is 1, or 0 when active-low is selected.
- R10: With the enable off, host_irq is held at its inactive level, which is 0, or 1 when active-low is selected, whatever the status holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Device event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd |
| host_irq | output | 1 | Host interrupt line, polarity per configuration |

## Verification
On every cycle, the assertions check the local register effects. These are the set and clear aliases on the mask, the clearing done by an acknowledge and by a clear-on-read, a source pulse winning over a clear, and the status staying unchanged during a nondestructive read. They also check that the line sits at its inactive level while disabled and at its active level while an unmasked bit is pending. The bench scenarios cover what only a full sequence can show. These are the reset values seen through reads, read data matching across the two status views, toggling polarity while bits are pending, and the line falling again after the last unmasked bit is acknowledged or masked.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] RA_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] RA_MSET = 3'd1;
    localparam logic [ADDR_W-1:0] RA_MCLR = 3'd2;
    localparam logic [ADDR_W-1:0] RA_PEEK = 3'd3;
    localparam logic [ADDR_W-1:0] RA_TAKE = 3'd4;
    localparam logic [ADDR_W-1:0] RA_ACK  = 3'd5;
    localparam logic [ADDR_W-1:0] RA_CFG  = 3'd6;

    localparam int CFG_EN_BIT = 5;
    localparam int CFG_LO_BIT = 7;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_QUIET  = 2'd1,
        ST_RAISED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/hirq_status.sv
module hirq_status #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_evt,
    input  logic             ack_we,
    input  logic             take_rd,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] sts_q,
    output logic [WIDTH-1:0] sts_d
);
    logic [WIDTH-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (take_rd)
            clr_vec = '1;
        else if (ack_we)
            clr_vec = wdata;
        // a new event outranks any clear in the same cycle
        sts_d = (sts_q & ~clr_vec) | src_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= sts_d;
    end
endmodule

// File: rtl/hirq_mask.sv
module hirq_mask #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_full,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] mask_d
);
    always_comb begin
        mask_d = mask_q;
        if (wr_full)
            mask_d = wdata;
        else if (wr_set)
            mask_d = mask_q | wdata;
        else if (wr_clr)
            mask_d = mask_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= RST_VAL;
        else
            mask_q <= mask_d;
    end
endmodule

// File: rtl/hirq_out_fsm.sv
module hirq_out_fsm
    import hirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_d,
    input  logic lo_d,
    input  logic pend_d,
    output logic host_irq
);
    irq_state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:    if (en_d) state_nx = pend_d ? ST_RAISED : ST_QUIET;
            ST_QUIET:  if (!en_d) state_nx = ST_OFF;
                       else if (pend_d) state_nx = ST_RAISED;
            ST_RAISED: if (!en_d) state_nx = ST_OFF;
                       else if (!pend_d) state_nx = ST_QUIET;
            default:   state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_irq <= 1'b0;
        else
            host_irq <= (state_nx == ST_RAISED) ^ lo_d;
    end
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
    import hirq_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] MASK_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src_evt,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    output logic             host_irq
);
    localparam logic [WIDTH-1:0] CFG_KEEP =
        (WIDTH'(1) << CFG_EN_BIT) | (WIDTH'(1) << CFG_LO_BIT);

    logic [WIDTH-1:0] sts_q, sts_d, mask_q, mask_d, cfg_q, cfg_d;
    logic             cfg_en_q, cfg_lo_q;

    hirq_status #(.WIDTH(WIDTH)) status_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .ack_we(reg_wr && reg_addr == RA_ACK),
        .take_rd(reg_rd && reg_addr == RA_TAKE),
        .wdata(reg_wdata), .sts_q(sts_q), .sts_d(sts_d)
    );

    hirq_mask #(.WIDTH(WIDTH), .RST_VAL(MASK_RST)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .wr_full(reg_wr && reg_addr == RA_MASK),
        .wr_set(reg_wr && reg_addr == RA_MSET),
        .wr_clr(reg_wr && reg_addr == RA_MCLR),
        .wdata(reg_wdata), .mask_q(mask_q), .mask_d(mask_d)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && reg_addr == RA_CFG)
            cfg_d = reg_wdata & CFG_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_d;
    end

    assign cfg_en_q = cfg_q[CFG_EN_BIT];
    assign cfg_lo_q = cfg_q[CFG_LO_BIT];

    hirq_out_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .en_d(cfg_d[CFG_EN_BIT]), .lo_d(cfg_d[CFG_LO_BIT]),
        .pend_d(|(sts_d & ~mask_d)),
        .host_irq(host_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                RA_MASK:          reg_rdata = mask_q;
                RA_PEEK, RA_TAKE: reg_rdata = sts_q;
                RA_CFG:           reg_rdata = cfg_q;
                default:          reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk
    import hirq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] src_evt,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WIDTH-1:0] reg_wdata,
    input logic             host_irq,
    input logic [WIDTH-1:0] sts,
    input logic [WIDTH-1:0] mask,
    input logic             cfg_en,
    input logic             cfg_lo
);
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MSET) |=>
        (((mask & $past(reg_wdata)) == $past(reg_wdata)) &&
         ((mask & ~$past(reg_wdata)) == ($past(mask) & ~$past(reg_wdata)))));

    a_r3_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_MCLR) |=>
        (((mask & $past(reg_wdata)) == '0) &&
         ((mask & ~$past(reg_wdata)) == ($past(mask) & ~$past(reg_wdata)))));

    a_r4_peek_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == RA_PEEK && src_evt == '0) |=> $stable(sts));

    a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == RA_TAKE && src_evt == '0) |=> (sts == '0));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == RA_ACK && src_evt == '0) |=>
        ((sts & $past(reg_wdata)) == '0));

    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((sts & $past(src_evt)) == $past(src_evt)));

    a_r9_pending_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && ((sts & ~mask) != '0)) |-> (host_irq != cfg_lo));

    a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> (host_irq == cfg_lo));
endmodule

bind hirq_ctrl hirq_ctrl_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .host_irq(host_irq), .sts(sts_q), .mask(mask_q),
    .cfg_en(cfg_en_q), .cfg_lo(cfg_lo_q)
);

// File: tb/hirq_ctrl_tb.sv
module hirq_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] src_evt = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        host_irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_mask = 'h0001, m_sts = 0, m_en = 0, m_lo = 0;

    always #5 clk = ~clk;

    hirq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    function automatic int exp_irq();
        int act = (m_en != 0 && ((m_sts & ~m_mask) & 'hFFFF) != 0) ? 1 : 0;
        return act ^ m_lo;
    endfunction

    function automatic int exp_read(int a);
        case (a)
            0: return m_mask;
            3, 4: return m_sts;
            6: return (m_lo << 7) | (m_en << 5);
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one clock: compare line, drive, compare read data, advance model
    task automatic step(string tag, bit wr, bit rd, int a, int wd, int src);
        @(negedge clk);
        check({tag, " irq"}, int'(host_irq), exp_irq());
        reg_wr = wr; reg_rd = rd; reg_addr = a[2:0];
        reg_wdata = wd[15:0]; src_evt = src[15:0];
        #1;
        if (rd) check({tag, " rdata"}, int'(reg_rdata), exp_read(a));
        @(posedge clk);
        if (rd && a == 4) m_sts = 0;
        else if (wr && a == 5) m_sts = m_sts & ~wd;
        m_sts = (m_sts | src) & 'hFFFF;
        if (wr && a == 0) m_mask = wd & 'hFFFF;
        if (wr && a == 1) m_mask = (m_mask | wd) & 'hFFFF;
        if (wr && a == 2) m_mask = m_mask & ~wd & 'hFFFF;
        if (wr && a == 6) begin m_en = (wd >> 5) & 1; m_lo = (wd >> 7) & 1; end
    endtask

    task automatic idle(string tag); step(tag, 0, 0, 7, 0, 0); endtask
    task automatic wr(string tag, int a, int d); step(tag, 1, 0, a, d, 0); endtask
    task automatic rd(string tag, int a); step(tag, 0, 1, a, 0, 0); endtask
    task automatic ev(string tag, int s); step(tag, 0, 0, 7, 0, s); endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 R8 reset values
        rd("R1 reset mask", 0);
        rd("R8 reset cfg", 6);
        rd("R4 reset status", 3);
        wr("R1 mask write", 0, 'h00F0);
        rd("R1 mask read", 0);
        // R2 R3 aliases
        wr("R2 set alias", 1, 'h0301);
        rd("R2 readback", 0);
        wr("R3 clr alias", 2, 'h0011);
        rd("R3 readback", 0);
        rd("R3 alias reads zero", 1);
        rd("R3 alias reads zero", 2);
        rd("R3 ack reads zero", 5);
        wr("R1 clear mask", 0, 0);
        // R7 events latch, R4 peek
        ev("R7 event", 'h4401);
        ev("R7 event", 'h0080);
        idle("R7 hold");
        rd("R4 peek", 3);
        rd("R4 peek again", 3);
        // R6 ack
        wr("R6 ack", 5, 'h0400);
        rd("R6 peek", 3);
        rd("R6 take view", 4);
        rd("R5 after take", 3);
        // R7 event vs clears
        ev("R7 set", 'h0006);
        step("R7 ack vs event", 1, 0, 5, 'h0006, 'h0002);
        rd("R7 peek", 3);
        step("R7 take vs event", 0, 1, 4, 0, 'h0800);
        rd("R7 peek", 3);
        // R9 enable, masking
        wr("R9 enable", 6, 'h20);
        idle("R9 pending");
        rd("R8 cfg read", 6);
        wr("R9 mask bit", 1, 'h0800);
        idle("R9 masked");
        wr("R9 unmask", 2, 'h0800);
        idle("R9 raised");
        wr("R9 ack all", 5, 'hFFFF);
        idle("R9 low");
        wr("R8 active low", 6, 'hFFFF);
        rd("R8 cfg only bits", 6);
        ev("R9 active low event", 'h8000);
        idle("R9 active low");
        wr("R9 mask event", 1, 'h8000);
        idle("R9 active low masked");
        wr("R9 unmask", 2, 'hFFFF);
        // R10 disable both polarities
        wr("R10 disable low", 6, 'h80);
        idle("R10 inactive high");
        wr("R10 disable high", 6, 'h00);
        ev("R10 event", 'h00FF);
        idle("R10 inactive low");
        rd("R5 take", 4);
        wr("R9 enable", 6, 'h20);
        ev("R9 event", 'h0010);
        rd("R5 take clears", 4);
        idle("R5 line drops");
        idle("R5 end");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule